// File: doc/BRIEF.md
# MMC/SD Host Register Front End

This block is the software-visible register file of a small MMC/SD host controller. A processor on a 32-bit register bus loads a buffer base, a command argument, a block size and a block count, then writes a command word. That write launches the command toward a separate card-side engine through a one-cycle start pulse. The command word, argument, buffer base and block setup are held steady on output ports while the engine works.

The engine reports back through event inputs: command finished with a response, data phase finished, or command timed out. Two card-status inputs report whether a card is present and whether it is write protected. The block latches responses into four response words and records events as sticky status bits that software clears by writing ones. It drives a single level-sensitive interrupt for every status bit whose enable bit is set. Bus signalling, CRC and data movement belong to the engine and are not part of this block.

Top module: `mmc_regfront`

## Requirements
- R1: The register byte offsets are 0x00 status, 0x04 interrupt enable, 0x08 buffer base, 0x0C command, 0x10 argument, 0x14/0x18/0x1C/0x20 response words 0 to 3, 0x24 block length, 0x28 block count and 0x2C card state. Every register resets to zero, and unmapped offsets read zero. A read returns data on reg_rdata in the cycle after reg_rd is sampled.
- R2: The command register keeps only bits 5:0 (opcode), 6 (open-drain), 9:8 (response kind: 0 none, 1 short, 2 long 136-bit, 3 OCR), 11 (busy wait), 13:12 (command kind: 0 BC, 1 BCR, 2 AC, 3 ADTC) and 15 (read direction), so a write of 0xFFFF reads back 0xBB7F. A write accepted while idle pulses cmd_start high for one cycle, starting in the cycle after the write, with the new word on cmd_word.
- R3: While a command is in progress, card-state bit 2 reads 1, and writes to the command register are ignored: no start pulse and no change to the stored word.
- R4: Block length and block count are 11-bit fields that hold the value minus one, and upper bits are dropped.
- R5: Status bits are bit 0 end of command, bit 1 end of data, bit 2 card change and bit 3 timeout. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: irq is high exactly when some status bit and its enable bit (enable register bits 3:0) are both set. An enable value of zero masks every source.
- R7: A timeout sets status bit 3. It does not set bit 0 for that command, even when a command-done event arrives in the same cycle. It latches no response and ends the busy state.
- R8: For a long response, the four response words take engine response bits 31:0, 63:32, 95:64 and 127:96 at offsets 0x14 to 0x20.
- R9: A short or OCR response updates only response word 0, and a command with response kind none updates no response word.
- R10: Status bit 1 is set, and busy ends, only for an ADTC command launched with a nonzero block length or block count, once the engine reports data done. For any other command, busy ends at command done and a data-done event is ignored.
- R11: Card state bit 0 shows card present and bit 1 shows write protect. Any change of either sets status bit 2.
- R12: Writes to the response words and to the card state register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| eng_cmd_done | input | 1 | Engine: command finished, response valid |
| eng_data_done | input | 1 | Engine: all blocks transferred |
| eng_timeout | input | 1 | Engine: command timed out |
| eng_resp | input | 128 | Engine response bits |
| card_present | input | 1 | Card is inserted |
| card_wp | input | 1 | Card is write protected |
| cmd_start | output | 1 | One-cycle launch pulse to the engine |
| cmd_word | output | 16 | Stored command word |
| cmd_arg | output | 32 | Stored argument |
| buf_base | output | 32 | Stored buffer base address |
| blk_len | output | 11 | Block length minus one |
| blk_cnt | output | 11 | Block count minus one |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is the same-cycle collision of a command-done event and a timeout on one outstanding command. The correct outcome is then an absence: no end-of-command bit and no new response. The stimulus first loads a known response, then launches a short-response command. It raises both engine events in the same clock with a different response value, and reads back status, response word 0 and busy. A second hard case is a data-done event for a command with no data phase. Commands are launched both with zeroed block setup and with a non-ADTC kind, and status is read after the stray event.

// File: rtl/mmc_rf_pkg.sv
package mmc_rf_pkg;
  localparam int ADDR_W = 6;
  localparam int NEV    = 4;
  localparam int CMD_W  = 16;

  localparam logic [ADDR_W-1:0] A_STAT = 6'h00;
  localparam logic [ADDR_W-1:0] A_IEN  = 6'h04;
  localparam logic [ADDR_W-1:0] A_BUF  = 6'h08;
  localparam logic [ADDR_W-1:0] A_CMD  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_ARG  = 6'h10;
  localparam logic [ADDR_W-1:0] A_RSP0 = 6'h14;
  localparam logic [ADDR_W-1:0] A_LEN  = 6'h24;
  localparam logic [ADDR_W-1:0] A_CNT  = 6'h28;
  localparam logic [ADDR_W-1:0] A_CARD = 6'h2C;

  // kept command bits: opcode, open-drain, response kind, busy wait, command kind, read
  localparam logic [CMD_W-1:0] CMD_KEEP = 16'hBB7F;

  localparam int EV_CMD  = 0;
  localparam int EV_DATA = 1;
  localparam int EV_CHG  = 2;
  localparam int EV_TMO  = 3;

  typedef enum logic [1:0] {CK_BC, CK_BCR, CK_AC, CK_ADTC} cmd_kind_t;
  typedef enum logic [1:0] {RK_NONE, RK_SHORT, RK_LONG, RK_OCR} rsp_kind_t;
endpackage

// File: rtl/mmc_rf_irq.sv
module mmc_rf_irq
  import mmc_rf_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] ev,
  input  logic           clr_wr,
  input  logic           en_wr,
  input  logic [NEV-1:0] wdata,
  output logic [NEV-1:0] stat_q,
  output logic [NEV-1:0] en_q,
  output logic           irq
);
  logic [NEV-1:0] stat_n;
  logic [NEV-1:0] en_n;

  // a new event wins over a clear in the same cycle
  always_comb begin
    stat_n = (stat_q & ~(clr_wr ? wdata : '0)) | ev;
    en_n   = en_wr ? wdata : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_n;
      en_q   <= en_n;
      irq    <= |(stat_n & en_n);
    end
  end
endmodule

// File: rtl/mmc_rf_cmd.sv
module mmc_rf_cmd
  import mmc_rf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LEN_W = 11,
  parameter int NRSP  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_wdata,
  input  logic [LEN_W-1:0]   len_q,
  input  logic [LEN_W-1:0]   cnt_q,
  input  logic               eng_cmd_done,
  input  logic               eng_data_done,
  input  logic               eng_timeout,
  input  logic [NRSP*DW-1:0] eng_resp,
  output logic [CMD_W-1:0]   cmd_q,
  output logic               start,
  output logic               busy,
  output logic [NRSP*DW-1:0] rsp_q,
  output logic [NEV-1:0]     ev
);
  logic      cmd_pend, data_pend;
  logic      accept, has_data, cmd_ok, dat_ok, tmo;
  rsp_kind_t rk;

  assign rk       = rsp_kind_t'(cmd_q[9:8]);
  assign busy     = cmd_pend | data_pend;
  assign accept   = cmd_wr & ~busy;
  assign has_data = (cmd_kind_t'(cmd_wdata[13:12]) == CK_ADTC) &&
                    ((len_q != '0) || (cnt_q != '0));
  assign tmo      = busy & eng_timeout;
  assign cmd_ok   = cmd_pend & eng_cmd_done & ~eng_timeout;
  assign dat_ok   = data_pend & eng_data_done & ~eng_timeout;

  always_comb begin
    ev         = '0;
    ev[EV_CMD] = cmd_ok;
    ev[EV_DATA] = dat_ok;
    ev[EV_TMO] = tmo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      start     <= 1'b0;
      cmd_pend  <= 1'b0;
      data_pend <= 1'b0;
    end else begin
      start <= accept;
      if (accept) begin
        cmd_q     <= cmd_wdata & CMD_KEEP;
        cmd_pend  <= 1'b1;
        data_pend <= has_data;
      end else if (tmo) begin
        cmd_pend  <= 1'b0;
        data_pend <= 1'b0;
      end else begin
        if (cmd_ok) cmd_pend  <= 1'b0;
        if (dat_ok) data_pend <= 1'b0;
      end
    end
  end

  // word 0 takes every response kind but none; the upper words only a long one
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q <= '0;
    end else if (cmd_ok) begin
      for (int i = 0; i < NRSP; i++) begin
        if ((i == 0) ? (rk != RK_NONE) : (rk == RK_LONG))
          rsp_q[i*DW +: DW] <= eng_resp[i*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/mmc_regfront.sv
module mmc_regfront
  import mmc_rf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LEN_W = 11,
  parameter int NRSP  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic               eng_cmd_done,
  input  logic               eng_data_done,
  input  logic               eng_timeout,
  input  logic [NRSP*DW-1:0] eng_resp,
  input  logic               card_present,
  input  logic               card_wp,
  output logic               cmd_start,
  output logic [CMD_W-1:0]   cmd_word,
  output logic [DW-1:0]      cmd_arg,
  output logic [DW-1:0]      buf_base,
  output logic [LEN_W-1:0]   blk_len,
  output logic [LEN_W-1:0]   blk_cnt,
  output logic               irq
);
  logic [DW-1:0]      buf_q, arg_q, rd_mux;
  logic [LEN_W-1:0]   len_q, cnt_q;
  logic [1:0]         card_q;
  logic               card_chg, busy;
  logic [NRSP*DW-1:0] rsp_q;
  logic [NEV-1:0]     cmd_ev, ev_all, stat_q, en_q;

  assign card_chg = card_q != {card_wp, card_present};

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q  <= '0;
      arg_q  <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      card_q <= '0;
    end else begin
      card_q <= {card_wp, card_present};
      if (reg_wr) begin
        if (reg_addr == A_BUF) buf_q <= reg_wdata;
        if (reg_addr == A_ARG) arg_q <= reg_wdata;
        if (reg_addr == A_LEN) len_q <= reg_wdata[LEN_W-1:0];
        if (reg_addr == A_CNT) cnt_q <= reg_wdata[LEN_W-1:0];
      end
    end
  end

  mmc_rf_cmd #(.DW(DW), .LEN_W(LEN_W), .NRSP(NRSP)) u_cmd (
    .clk(clk), .rst(rst),
    .cmd_wr(reg_wr && reg_addr == A_CMD), .cmd_wdata(reg_wdata[CMD_W-1:0]),
    .len_q(len_q), .cnt_q(cnt_q),
    .eng_cmd_done(eng_cmd_done), .eng_data_done(eng_data_done),
    .eng_timeout(eng_timeout), .eng_resp(eng_resp),
    .cmd_q(cmd_word), .start(cmd_start), .busy(busy),
    .rsp_q(rsp_q), .ev(cmd_ev)
  );

  always_comb begin
    ev_all         = cmd_ev;
    ev_all[EV_CHG] = card_chg;
  end

  mmc_rf_irq u_irq (
    .clk(clk), .rst(rst), .ev(ev_all),
    .clr_wr(reg_wr && reg_addr == A_STAT),
    .en_wr(reg_wr && reg_addr == A_IEN),
    .wdata(reg_wdata[NEV-1:0]),
    .stat_q(stat_q), .en_q(en_q), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_STAT:  rd_mux[NEV-1:0]   = stat_q;
      A_IEN:   rd_mux[NEV-1:0]   = en_q;
      A_BUF:   rd_mux            = buf_q;
      A_CMD:   rd_mux[CMD_W-1:0] = cmd_word;
      A_ARG:   rd_mux            = arg_q;
      A_LEN:   rd_mux[LEN_W-1:0] = len_q;
      A_CNT:   rd_mux[LEN_W-1:0] = cnt_q;
      A_CARD:  rd_mux[2:0]       = {busy, card_q};
      default: rd_mux = '0;
    endcase
    for (int i = 0; i < NRSP; i++) begin
      if (reg_addr == A_RSP0 + ADDR_W'(4 * i)) rd_mux = rsp_q[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign cmd_arg  = arg_q;
  assign buf_base = buf_q;
  assign blk_len  = len_q;
  assign blk_cnt  = cnt_q;
endmodule

// File: rtl/mmc_regfront_chk.sv
module mmc_regfront_chk
  import mmc_rf_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              cmd_start,
  input logic              busy,
  input logic              eng_timeout,
  input logic              eng_data_done,
  input logic [NEV-1:0]    stat_q,
  input logic [NEV-1:0]    en_q,
  input logic              irq
);
  assert_start_from_write_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> $past(reg_wr && reg_addr == A_CMD));

  assert_busy_blocks_launch_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_CMD && busy) |=> !cmd_start);

  assert_irq_level_R6: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q & en_q));

  assert_timeout_no_end_R7: assert property (@(posedge clk) disable iff (rst)
    eng_timeout |=> !$rose(stat_q[EV_CMD]));

  assert_data_end_from_engine_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[EV_DATA]) |-> $past(eng_data_done));
endmodule

bind mmc_regfront mmc_regfront_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .cmd_start(cmd_start), .busy(busy), .eng_timeout(eng_timeout),
  .eng_data_done(eng_data_done), .stat_q(stat_q), .en_q(en_q), .irq(irq)
);

// File: tb/mmc_regfront_test.sv
`timescale 1ns/1ps
module mmc_regfront_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         eng_cmd_done = 1'b0, eng_data_done = 1'b0, eng_timeout = 1'b0;
  logic [127:0] eng_resp = '0;
  logic         card_present = 1'b0, card_wp = 1'b0;
  logic         cmd_start, irq;
  logic [15:0]  cmd_word;
  logic [31:0]  cmd_arg, buf_base;
  logic [10:0]  blk_len, blk_cnt;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  mmc_regfront uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_cmd_done(eng_cmd_done), .eng_data_done(eng_data_done),
    .eng_timeout(eng_timeout), .eng_resp(eng_resp),
    .card_present(card_present), .card_wp(card_wp),
    .cmd_start(cmd_start), .cmd_word(cmd_word), .cmd_arg(cmd_arg),
    .buf_base(buf_base), .blk_len(blk_len), .blk_cnt(blk_cnt), .irq(irq)
  );

  // {offset, write value, expected read}
  localparam logic [69:0] VEC [0:8] = '{
    {6'h08, 32'hDEADBEEF, 32'hDEADBEEF},  // R1 buffer base
    {6'h10, 32'h12345678, 32'h12345678},  // R1 argument
    {6'h24, 32'hFFFFFFFF, 32'h000007FF},  // R4 length kept to 11 bits
    {6'h28, 32'h00000ABC, 32'h000002BC},  // R4 count kept to 11 bits
    {6'h04, 32'hFFFFFFFF, 32'h0000000F},  // R6 enable 4 bits
    {6'h04, 32'h00000000, 32'h00000000},  // R6 enable cleared
    {6'h14, 32'h0000FFFF, 32'h00000000},  // R12 response read-only
    {6'h2C, 32'h000000FF, 32'h00000000},  // R12 card state read-only
    {6'h30, 32'hFFFFFFFF, 32'h00000000}   // R1 unmapped
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic eng(input logic cd, input logic dd, input logic to, input logic [127:0] r);
    @(negedge clk);
    eng_cmd_done = cd; eng_data_done = dd; eng_timeout = to; eng_resp = r;
    @(negedge clk);
    eng_cmd_done = 1'b0; eng_data_done = 1'b0; eng_timeout = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(6'h00, v); chk("R1 status reset", v, 32'h0);
    rd(6'h0C, v); chk("R1 command reset", v, 32'h0);
    rd(6'h24, v); chk("R1 length reset", v, 32'h0);
    chk("R6 irq reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rd(VEC[i][69:64], v);
      chk($sformatf("R1/R4/R12 vector %0d", i), v, VEC[i][31:0]);
    end
    chk("R4 blk_len port", {21'b0, blk_len}, 32'h7FF);
    wr(6'h24, 32'h0);
    wr(6'h28, 32'h0);

    // R2 launch: long response, BCR, open drain, opcode 2
    wr(6'h10, 32'h0000A5A5);
    wr(6'h0C, 32'h00001242);
    chk("R2 start pulse", {31'b0, cmd_start}, 32'h1);
    chk("R2 cmd_word", {16'b0, cmd_word}, 32'h1242);
    chk("R2 cmd_arg", cmd_arg, 32'hA5A5);
    rd(6'h2C, v); chk("R3 busy bit", v, 32'h4);
    wr(6'h0C, 32'h00000011);
    chk("R3 no start while busy", {31'b0, cmd_start}, 32'h0);
    rd(6'h0C, v); chk("R3 command kept", v, 32'h1242);
    eng(1'b1, 1'b0, 1'b0, {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111});
    rd(6'h14, v); chk("R8 word0", v, 32'h11111111);
    rd(6'h18, v); chk("R8 word1", v, 32'h22222222);
    rd(6'h20, v); chk("R8 word3", v, 32'h44444444);
    rd(6'h00, v); chk("R5 end of command", v, 32'h1);
    rd(6'h2C, v); chk("R10 idle after no-data command", v, 32'h0);
    chk("R6 masked irq", {31'b0, irq}, 32'h0);
    wr(6'h04, 32'h1);
    chk("R6 irq enabled", {31'b0, irq}, 32'h1);
    wr(6'h00, 32'h0);
    rd(6'h00, v); chk("R5 write zero keeps", v, 32'h1);
    wr(6'h00, 32'h1);
    rd(6'h00, v); chk("R5 write one clears", v, 32'h0);
    chk("R6 irq drops", {31'b0, irq}, 32'h0);

    // R2 mask and R9 OCR response updates word 0 only
    wr(6'h0C, 32'h0000FFFF);
    rd(6'h0C, v); chk("R2 mask", v, 32'h0000BB7F);
    eng(1'b1, 1'b0, 1'b0, {32'h0, 32'h0, 32'h0, 32'hCAFE0001});
    rd(6'h14, v); chk("R9 word0 updated", v, 32'hCAFE0001);
    rd(6'h18, v); chk("R9 word1 kept", v, 32'h22222222);
    wr(6'h00, 32'hF);

    // R7 timeout colliding with command done
    wr(6'h0C, 32'h00000111);
    eng(1'b1, 1'b0, 1'b1, {96'h0, 32'h00009999});
    rd(6'h00, v); chk("R7 timeout only", v, 32'h8);
    rd(6'h14, v); chk("R7 no response latch", v, 32'hCAFE0001);
    rd(6'h2C, v); chk("R7 busy ended", v, 32'h0);
    wr(6'h04, 32'hF);
    chk("R6 irq on timeout", {31'b0, irq}, 32'h1);
    wr(6'h04, 32'h0);
    chk("R6 enable zero masks", {31'b0, irq}, 32'h0);
    wr(6'h00, 32'hF);

    // R10 ADTC read with data phase
    wr(6'h24, 32'h1FF);
    wr(6'h28, 32'h1);
    wr(6'h0C, 32'h0000B111);
    eng(1'b1, 1'b0, 1'b0, {96'h0, 32'h00000900});
    rd(6'h00, v); chk("R10 command end before data", v, 32'h1);
    rd(6'h2C, v); chk("R10 busy during data", v, 32'h4);
    eng(1'b0, 1'b1, 1'b0, 128'h0);
    rd(6'h00, v); chk("R10 end of data", v, 32'h3);
    rd(6'h2C, v); chk("R10 idle after data", v, 32'h0);
    wr(6'h00, 32'hF);

    // R10 ADTC with zero block setup: no data phase
    wr(6'h24, 32'h0);
    wr(6'h28, 32'h0);
    wr(6'h0C, 32'h00003111);
    eng(1'b1, 1'b0, 1'b0, 128'h0);
    rd(6'h2C, v); chk("R10 zero setup idle", v, 32'h0);
    eng(1'b0, 1'b1, 1'b0, 128'h0);
    rd(6'h00, v); chk("R10 stray data ignored", v, 32'h1);
    wr(6'h00, 32'hF);

    // R10 AC with block setup: still no data phase
    wr(6'h24, 32'h1FF);
    wr(6'h0C, 32'h00002111);
    eng(1'b1, 1'b0, 1'b0, 128'h0);
    eng(1'b0, 1'b1, 1'b0, 128'h0);
    rd(6'h00, v); chk("R10 AC no data end", v, 32'h1);
    wr(6'h00, 32'hF);

    // R11 card state
    @(negedge clk); card_present = 1'b1;
    repeat (2) @(negedge clk);
    rd(6'h00, v); chk("R11 change on insert", v, 32'h4);
    rd(6'h2C, v); chk("R11 present bit", v, 32'h1);
    wr(6'h04, 32'h4);
    chk("R6 irq on card change", {31'b0, irq}, 32'h1);
    wr(6'h00, 32'h4);
    @(negedge clk); card_wp = 1'b1;
    repeat (2) @(negedge clk);
    rd(6'h00, v); chk("R11 change on protect", v, 32'h4);
    rd(6'h2C, v); chk("R11 protect bit", v, 32'h3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule